// File: doc/BRIEF.md
# Four-address memory-to-memory processor

This block is a small multicycle processor with no program counter and no working registers that software can see. Each instruction names where its two source operands live, where the result goes, and where the following instruction starts. All four of these are 24-bit byte addresses into one 16 MB space. The core reaches that space through a single byte-wide synchronous memory port with a request/ready handshake.

An instruction is 13 bytes long. The core reads those bytes one at a time, then reads two 32-bit operands of four bytes each and computes a sum, a difference or the low half of a product. It writes the four result bytes back and fetches the next instruction from the address carried in the instruction itself. After reset, the first fetch address comes from a boot-address input. A halt opcode stops the machine. An undefined opcode stops it as well and also raises a flag.

Top module: `quad_addr_cpu`

## Requirements
- R1: While `rstN` is low the block makes no memory request and `halted`, `done` and `illegal` are low. The first request after reset is a read at the address on `bootAddr`.
- R2: An instruction is read as 13 bytes at consecutive addresses starting at the fetch address. Byte 0 is the opcode. Bytes 1-3 hold the first operand address, bytes 4-6 the second operand address, bytes 7-9 the result address and bytes 10-12 the next-instruction address. Each address is stored most significant byte first.
- R3: Operands and results are 32 bits, stored as 4 bytes at address..address+3, most significant byte first. Both operands are read before any result byte is written, so a result address that equals a source address is handled correctly.
- R4: Opcode 0x01 writes op1 + op2 modulo 2^32.
- R5: Opcode 0x02 writes op1 - op2 modulo 2^32.
- R6: Opcode 0x03 writes the low 32 bits of op1 * op2.
- R7: The next fetch uses the next-instruction field only. Nothing is fetched from the bytes that follow the instruction.
- R8: `done` is high for exactly one cycle per executed instruction, in the cycle where the last result byte write is accepted.
- R9: Opcode 0xFF raises `halted`, which stays high until reset. It causes no operand read and no result write, and `illegal` stays low.
- R10: Any opcode other than 0x01, 0x02, 0x03 or 0xFF halts the machine with `illegal` high and writes nothing.
- R11: A request keeps its address, write enable and write data unchanged until `memReady` is seen high. The read byte is taken from `memRdata` in the cycle after the read was accepted, and correct results come out under any pattern of wait cycles.
- R12: Every byte address is computed modulo 2^24, so instructions and operands may wrap from 0xFFFFFF to 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootAddr | input | 24 | Address of the first instruction after reset |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write (1) or a read (0) |
| memAddr | output | 24 | Byte address of the request |
| memWdata | output | 8 | Byte to write |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 8 | Read byte, valid the cycle after an accepted read |
| done | output | 1 | One-cycle pulse when an instruction's result is fully written |
| halted | output | 1 | Machine has stopped |
| illegal | output | 1 | Machine stopped on an undefined opcode |

## Verification
The bench builds the block with its default widths: 24-bit addresses and 32-bit operands. It backs them with a 4 KB memory model that aliases the address space, which brings both ends of the 24-bit range within reach. For each arithmetic opcode it runs a chained program covering all 64 pairs drawn from eight corner operands (zero, one, two, both sign boundaries, all ones and two mixed patterns), once with a ready line that never stalls and once with a line that stalls every third cycle. Further programs jump out of order with an illegal trap at the sequential successor, write results over their own sources, wrap fetch and data addresses across the top of memory, and stop on the halt opcode and on several undefined opcodes.

// File: rtl/qac_pkg.sv
package qac_pkg;

  // Width of the byte counter carried in the strobe bundle
  localparam int IDX_W = 6;

  localparam logic [7:0] OP_ADD  = 8'h01;
  localparam logic [7:0] OP_SUB  = 8'h02;
  localparam logic [7:0] OP_MUL  = 8'h03;
  localparam logic [7:0] OP_HALT = 8'hFF;

  // Which object the byte transfers currently target
  typedef enum logic [1:0] {
    PH_FETCH,
    PH_OPA,
    PH_OPB,
    PH_WRITE
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    phase_e           phase;
    logic [IDX_W-1:0] byteIdx;
    logic             capture;   // shift memRdata into the phase's register
    logic             advance;   // fetch address <= next-instruction field
    logic             loadBoot;  // fetch address <= bootAddr
  } strobe_t;

endpackage

// File: rtl/qac_ctrl.sv
module qac_ctrl
  import qac_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReady,
  input  logic [7:0] opcode,
  output logic       memReq,
  output logic       memWe,
  output logic       done,
  output logic       halted,
  output logic       illegal,
  output strobe_t    strobe
);

  localparam int INSTR_BYTES = 1 + 4 * (ADDR_W / 8);
  localparam int OPER_BYTES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_REQ,
    ST_CAP,
    ST_DEC,
    ST_HALT
  } state_e;

  state_e           state, stateNext;
  phase_e           phase, phaseNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             illegalNext;
  logic             lastByte;
  logic             knownOp;

  always_comb begin
    if (phase == PH_FETCH) lastByte = (idx == IDX_W'(INSTR_BYTES - 1));
    else                   lastByte = (idx == IDX_W'(OPER_BYTES - 1));
    knownOp = (opcode == OP_ADD) || (opcode == OP_SUB) || (opcode == OP_MUL);
  end

  always_comb begin
    stateNext       = state;
    phaseNext       = phase;
    idxNext         = idx;
    illegalNext     = illegal;
    memReq          = 1'b0;
    memWe           = 1'b0;
    done            = 1'b0;
    strobe.phase    = phase;
    strobe.byteIdx  = idx;
    strobe.capture  = 1'b0;
    strobe.advance  = 1'b0;
    strobe.loadBoot = 1'b0;
    case (state)
      ST_BOOT: begin
        strobe.loadBoot = 1'b1;
        stateNext       = ST_REQ;
      end
      ST_REQ: begin
        memReq = 1'b1;
        memWe  = (phase == PH_WRITE);
        if (memReady) begin
          if (phase == PH_WRITE) begin
            if (lastByte) begin
              done           = 1'b1;
              strobe.advance = 1'b1;
              phaseNext      = PH_FETCH;
              idxNext        = '0;
            end else begin
              idxNext = idx + 1'b1;
            end
          end else begin
            stateNext = ST_CAP;
          end
        end
      end
      ST_CAP: begin
        strobe.capture = 1'b1;
        if (lastByte) begin
          idxNext = '0;
          case (phase)
            PH_FETCH: stateNext = ST_DEC;
            PH_OPA: begin
              phaseNext = PH_OPB;
              stateNext = ST_REQ;
            end
            default: begin
              phaseNext = PH_WRITE;
              stateNext = ST_REQ;
            end
          endcase
        end else begin
          idxNext   = idx + 1'b1;
          stateNext = ST_REQ;
        end
      end
      ST_DEC: begin
        if (knownOp) begin
          phaseNext = PH_OPA;
          stateNext = ST_REQ;
        end else begin
          stateNext   = ST_HALT;
          illegalNext = (opcode != OP_HALT);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      phase   <= PH_FETCH;
      idx     <= '0;
      illegal <= 1'b0;
    end else begin
      state   <= stateNext;
      phase   <= phaseNext;
      idx     <= idxNext;
      illegal <= illegalNext;
    end
  end

  assign halted = (state == ST_HALT);

endmodule

// File: rtl/qac_dpath.sv
module qac_dpath
  import qac_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] bootAddr,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        opcode
);

  localparam int INSTR_BYTES = 1 + 4 * (ADDR_W / 8);
  localparam int INSTR_W     = 8 * INSTR_BYTES;

  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  opA, opB, result, shifted;
  logic [ADDR_W-1:0]  fetchAddr, base;
  logic [ADDR_W-1:0]  op1Addr, op2Addr, resAddr, nextAddr;

  // Field layout, most significant byte of the instruction first
  assign opcode   = instr[INSTR_W-1 -: 8];
  assign op1Addr  = instr[4*ADDR_W-1 -: ADDR_W];
  assign op2Addr  = instr[3*ADDR_W-1 -: ADDR_W];
  assign resAddr  = instr[2*ADDR_W-1 -: ADDR_W];
  assign nextAddr = instr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
      instr     <= '0;
      opA       <= '0;
      opB       <= '0;
    end else begin
      if (strobe.loadBoot)     fetchAddr <= bootAddr;
      else if (strobe.advance) fetchAddr <= nextAddr;
      if (strobe.capture) begin
        case (strobe.phase)
          PH_FETCH: instr <= {instr[INSTR_W-9:0], memRdata};
          PH_OPA:   opA   <= {opA[DATA_W-9:0], memRdata};
          PH_OPB:   opB   <= {opB[DATA_W-9:0], memRdata};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (opcode)
      OP_SUB:  result = opA - opB;
      OP_MUL:  result = opA * opB;
      default: result = opA + opB;
    endcase
    case (strobe.phase)
      PH_FETCH: base = fetchAddr;
      PH_OPA:   base = op1Addr;
      PH_OPB:   base = op2Addr;
      default:  base = resAddr;
    endcase
    shifted = result << (8 * strobe.byteIdx);
  end

  assign memAddr  = base + ADDR_W'(strobe.byteIdx);
  assign memWdata = shifted[DATA_W-1 -: 8];

endmodule

// File: rtl/quad_addr_cpu.sv
module quad_addr_cpu
  import qac_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] bootAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic              memReady,
  input  logic [7:0]        memRdata,
  output logic              done,
  output logic              halted,
  output logic              illegal
);

  strobe_t    strobe;
  logic [7:0] opcode;

  qac_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .memReady (memReady),
    .opcode   (opcode),
    .memReq   (memReq),
    .memWe    (memWe),
    .done     (done),
    .halted   (halted),
    .illegal  (illegal),
    .strobe   (strobe)
  );

  qac_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bootAddr (bootAddr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );

endmodule

// File: rtl/qac_chk.sv
module qac_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              memReady,
  input logic              done,
  input logic              halted,
  input logic              illegal
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!memReq && !done && !halted && !illegal);
    end
  end

  // R11
  held_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> memReq && memWe && memReady);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memReq && !done);

  // R10
  illegal_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted);

endmodule

bind quad_addr_cpu qac_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady),
  .done     (done),
  .halted   (halted),
  .illegal  (illegal)
);

// File: tb/sim_quad_addr_cpu.sv
module sim_quad_addr_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 32;
  localparam int MEM_MASK   = 12'hFFF;
  localparam int RUN_LIMIT  = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] bootAddr = '0;
  logic              memReq, memWe, done, halted, illegal;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata;
  logic              memReady = 1'b1;
  logic [7:0]        memRdata = 8'h00;

  logic [7:0] mem [4096];
  int checks = 0;
  int fails = 0;
  int doneCount = 0;
  int stallCnt = 0;
  logic stallMode = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_addr_cpu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .bootAddr(bootAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata),
    .done(done), .halted(halted), .illegal(illegal)
  );

  // Memory model: 4 KB aliased over the 24-bit space
  always @(posedge clk) begin
    if (rstN && memReq && memReady) begin
      if (memWe) mem[memAddr[11:0]] = memWdata;
      else       memRdata <= mem[memAddr[11:0]];
    end
    if (rstN && done) doneCount = doneCount + 1;
  end

  always @(negedge clk) begin
    stallCnt = stallCnt + 1;
    memReady = stallMode ? ((stallCnt % 3) != 0) : 1'b1;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic putByte(input int a, input logic [7:0] b);
    mem[a & MEM_MASK] = b;
  endtask

  task automatic putWord(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) putByte(a + i, w[31 - 8*i -: 8]);
  endtask

  function automatic logic [31:0] getWord(input int a);
    return {mem[a & MEM_MASK], mem[(a + 1) & MEM_MASK], mem[(a + 2) & MEM_MASK], mem[(a + 3) & MEM_MASK]};
  endfunction

  task automatic putAddr(input int at, input int v);
    putByte(at, 8'(v >> 16));
    putByte(at + 1, 8'(v >> 8));
    putByte(at + 2, 8'(v));
  endtask

  task automatic putInstr(input int at, input logic [7:0] opc, input int a, input int b, input int r, input int n);
    putByte(at, opc);
    putAddr(at + 1, a);
    putAddr(at + 4, b);
    putAddr(at + 7, r);
    putAddr(at + 10, n);
  endtask

  // Reset, start at boot, run until halted
  task automatic runProg(input int boot);
    int cyc;
    logic seenReq;
    rstN = 1'b0;
    bootAddr = ADDR_W'(boot);
    repeat (3) @(negedge clk);
    doneCount = 0;
    // R1 reset state
    check(!memReq && !done && !halted && !illegal, "R1 reset outputs",
          {28'd0, memReq, done, halted, illegal}, 32'd0);
    rstN = 1'b1;
    cyc = 0;
    seenReq = 1'b0;
    while (!halted && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (memReq && !seenReq) begin
        seenReq = 1'b1;
        // R1 first request reads at bootAddr
        check(!memWe && memAddr == ADDR_W'(boot), "R1 first fetch address",
              {7'd0, memWe, memAddr}, {8'd0, 24'(boot)});
      end
    end
    if (!halted) check(1'b0, "watchdog run limit", 32'(cyc), 32'(RUN_LIMIT));
  endtask

  logic [31:0] vals [8];
  logic [31:0] expv;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h0000_0002; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
    vals[6] = 32'h1234_5678; vals[7] = 32'hDEAD_BEEF;

    // R4 R5 R6 sweeps, with and without wait cycles (R11), chained by next field (R2 R7)
    for (int st = 0; st < 2; st++) begin
      for (int op = 1; op <= 3; op++) begin
        stallMode = (st == 1);
        for (int i = 0; i < 8; i++) putWord(12'hC00 + 4*i, vals[i]);
        for (int k = 0; k < 64; k++) begin
          putWord(12'hD00 + 4*k, 32'hA5A5_A5A5);
          putInstr(13*k, 8'(op), 12'hC00 + 4*(k / 8), 12'hC00 + 4*(k % 8), 12'hD00 + 4*k, 13*(k + 1));
        end
        putInstr(13*64, 8'hFF, 0, 0, 0, 0);
        runProg(0);
        for (int k = 0; k < 64; k++) begin
          case (op)
            1: expv = vals[k / 8] + vals[k % 8];
            2: expv = vals[k / 8] - vals[k % 8];
            default: expv = vals[k / 8] * vals[k % 8];
          endcase
          if (op == 1)      check(getWord(12'hD00 + 4*k) == expv, "R4 add result (R11 stalls)", getWord(12'hD00 + 4*k), expv);
          else if (op == 2) check(getWord(12'hD00 + 4*k) == expv, "R5 sub result (R11 stalls)", getWord(12'hD00 + 4*k), expv);
          else              check(getWord(12'hD00 + 4*k) == expv, "R6 mul result (R11 stalls)", getWord(12'hD00 + 4*k), expv);
        end
        check(doneCount == 64, "R8 done pulses per program", 32'(doneCount), 32'd64);
        check(!illegal, "R9 clean halt at end of chain", {31'd0, illegal}, 32'd0);
      end
    end
    stallMode = 1'b0;

    // R7 out-of-order jumps with a trap at the sequential successor; R3 in-place result
    putWord(12'hC00, 32'd5);
    putWord(12'hC04, 32'd7);
    putInstr(12'h100, 8'h01, 12'hC00, 12'hC04, 12'hE00, 12'h300);
    putInstr(12'h10D, 8'h00, 0, 0, 0, 0);
    putInstr(12'h300, 8'h03, 12'hE00, 12'hE00, 12'hE00, 12'h200);
    putInstr(12'h200, 8'h02, 12'hE00, 12'hC04, 12'hE04, 12'h180);
    putInstr(12'h180, 8'hFF, 0, 0, 0, 0);
    runProg(12'h100);
    check(!illegal, "R7 sequential trap not reached", {31'd0, illegal}, 32'd0);
    check(getWord(12'hE00) == 32'd144, "R3 in-place multiply", getWord(12'hE00), 32'd144);
    check(getWord(12'hE04) == 32'd137, "R7 jump chain result", getWord(12'hE04), 32'd137);
    check(doneCount == 3, "R8 done count for three instructions", 32'(doneCount), 32'd3);

    // R12 fetch wrap: instruction spans 0xFFFFF6..0x000002
    putInstr(24'hFFFFF6, 8'h01, 12'hC00, 12'hC04, 12'hE20, 12'h180);
    runProg(24'hFFFFF6);
    check(getWord(12'hE20) == 32'd12, "R12 fetch across top of memory", getWord(12'hE20), 32'd12);

    // R12 data wrap: operand and result cross 0xFFFFFF
    putWord(24'hFFFFFD, 32'h0102_0304);
    putInstr(12'h600, 8'h01, 24'hFFFFFD, 12'hC04, 24'hFFFFFE, 12'h180);
    runProg(12'h600);
    check(getWord(24'hFFFFFE) == 32'h0102_030B, "R12 data across top of memory",
          getWord(24'hFFFFFE), 32'h0102_030B);

    // R9 halt opcode: no write, sticky, quiet
    putWord(12'hE10, 32'h1122_3344);
    putInstr(12'h400, 8'hFF, 12'hC00, 12'hC04, 12'hE10, 12'h100);
    runProg(12'h400);
    repeat (20) @(negedge clk);
    check(halted && !illegal && !memReq, "R9 halt state held",
          {29'd0, halted, illegal, memReq}, 32'd4);
    check(getWord(12'hE10) == 32'h1122_3344, "R9 halt writes nothing", getWord(12'hE10), 32'h1122_3344);
    check(doneCount == 0, "R9 no done on halt", 32'(doneCount), 32'd0);

    // R10 undefined opcodes
    for (int j = 0; j < 4; j++) begin
      logic [7:0] bad;
      bad = (j == 0) ? 8'h00 : (j == 1) ? 8'h04 : (j == 2) ? 8'h80 : 8'hFE;
      putInstr(12'h500, bad, 12'hC00, 12'hC04, 12'hE10, 12'h100);
      runProg(12'h500);
      repeat (5) @(negedge clk);
      check(halted && illegal, "R10 undefined opcode flags", {30'd0, halted, illegal}, 32'd3);
      check(getWord(12'hE10) == 32'h1122_3344, "R10 undefined opcode writes nothing",
            getWord(12'hE10), 32'h1122_3344);
      check(doneCount == 0, "R10 no done on undefined opcode", 32'(doneCount), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule